// File: doc/BRIEF.md
# Grouped-Priority Interrupt Selector

This block picks the next interrupt to service out of 35 request lines. It also decides whether that request may interrupt the handler that is already running. Each source holds a 5-bit urgency value and an enable bit, both loaded through a simple write port. A smaller value is more urgent.

A 3-bit grouping control splits every urgency value into two parts. The upper part is the preemption group. The lower part is a tie-break level that only orders requests that are waiting together. Comparing the whole value as one number orders requests by group first and tie-break level second. Equal values fall back to the lower source number. Only the group part is compared against the running handler's value to raise the preempt flag.

The decision is computed from the current inputs and the stored priority state, and is captured into a small output state machine on each clock edge. A result therefore appears one cycle after its inputs. The output state machine has three states:

- `SEL_IDLE`: nothing to service.
- `SEL_QUEUE`: a winner exists but must wait behind the running handler.
- `SEL_PREEMPT`: a winner exists and may interrupt.

Every edge takes the transition named by the new decision, from any state:

- to IDLE when no enabled source is pending;
- to PREEMPT when the winner's group beats the active handler, or no handler is active;
- to QUEUE otherwise.

Top module: `grp_irq_select`

## Requirements
- R1: While reset is asserted, and on the first edge after it, `sel_valid`, `sel_preempt` and `sel_idx` are 0. All sources reset to disabled with urgency value 0.
- R2: A cycle with `cfg_we` high and `cfg_idx` below 35 stores `cfg_prio` and `cfg_enable` for that source. The new setting takes part in the decision made on the following edge. A write with `cfg_idx` of 35 or more changes nothing.
- R3: A source that is not pending, or not enabled, never wins. When no enabled source is pending, `sel_valid` is 0, `sel_preempt` is 0 and `sel_idx` is 0.
- R4: Among enabled pending sources, the one with the numerically smallest preemption group wins.
- R5: Among enabled pending sources with the same group, the one with the smaller tie-break level wins. For example, under grouping 4, values 1 and 2 are chosen in that order.
- R6: When enabled pending sources have identical urgency values, the lowest source number wins.
- R7: The number of tie-break bits is 0 for a grouping value of 0, 1 or 2, and equals the grouping value minus 2 for values 3 to 7. The group is the urgency value shifted right by that count.
- R8: When `act_valid` is 0 and a winner exists, `sel_preempt` is 1.
- R9: When `act_valid` is 1, `sel_preempt` is 1 only if the winner's group is strictly smaller than the group of `act_prio`. A smaller tie-break level within the same group does not preempt.
- R10: `sel_valid`, `sel_idx` and `sel_preempt` present, one clock after an edge, the decision formed from the inputs sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for one source's setting |
| cfg_idx | input | 6 | Source number written |
| cfg_prio | input | 5 | Urgency value written |
| cfg_enable | input | 1 | Enable bit written |
| req_pending | input | 35 | Pending request lines, one per source |
| grouping | input | 3 | Split between group bits and tie-break bits |
| act_valid | input | 1 | A handler is currently running |
| act_prio | input | 5 | Urgency value of the running handler |
| sel_idx | output | 6 | Winning source number (0 when none) |
| sel_valid | output | 1 | An enabled source is pending |
| sel_preempt | output | 1 | The winner may interrupt the running handler |

## Verification
A corrupted stored urgency value or enable bit shows up one cycle after the source is next requested, either as a wrong `sel_idx` or as a missing `sel_valid`. A wrong tie-break shift shows up only in `sel_preempt`, and only when the winner and the running handler differ in their low bits alone. The bench therefore sweeps every grouping value against a fixed pair of values. A wrong output state shows at once, because each state maps directly onto `sel_valid` and `sel_preempt`. The comparison is made every cycle, so any divergence is caught within one clock.

// File: rtl/grp_irq_pkg.sv
package grp_irq_pkg;

    // Registered decision of the selector.
    typedef enum logic [1:0] {
        SEL_IDLE    = 2'd0,
        SEL_QUEUE   = 2'd1,
        SEL_PREEMPT = 2'd2
    } sel_state_e;

endpackage

// File: rtl/grp_irq_prio_bank.sv
module grp_irq_prio_bank #(
    parameter int NUM_SRC = 35,
    parameter int PRIO_W  = 5,
    parameter int IDX_W   = $clog2(NUM_SRC)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_we,
    input  logic [IDX_W-1:0]          cfg_idx,
    input  logic [PRIO_W-1:0]         cfg_prio,
    input  logic                      cfg_enable,
    output logic [NUM_SRC*PRIO_W-1:0] prio_flat,
    output logic [NUM_SRC-1:0]        en_vec
);

    // One register slot per source.
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_slot
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g);

        logic              hit;
        logic [PRIO_W-1:0] prio_q;
        logic              en_q;

        assign hit = cfg_we && (cfg_idx == MY_IDX);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prio_q <= '0;
                en_q   <= 1'b0;
            end else if (hit) begin
                prio_q <= cfg_prio;
                en_q   <= cfg_enable;
            end
        end

        assign prio_flat[g*PRIO_W +: PRIO_W] = prio_q;
        assign en_vec[g]                     = en_q;
    end

endmodule

// File: rtl/grp_irq_min_pick.sv
module grp_irq_min_pick #(
    parameter int NUM_SRC = 35,
    parameter int PRIO_W  = 5,
    parameter int IDX_W   = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0]        live,
    input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
    output logic                      any,
    output logic [IDX_W-1:0]          best_idx,
    output logic [PRIO_W-1:0]         best_prio
);

    // Scan from the lowest source up. A strict compare keeps the earlier
    // (lower-numbered) source on equal values. Comparing the whole value
    // orders by group first and tie-break level second, for every split.
    always_comb begin
        any       = 1'b0;
        best_idx  = '0;
        best_prio = '1;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (live[i] && (!any || (prio_flat[i*PRIO_W +: PRIO_W] < best_prio))) begin
                any       = 1'b1;
                best_idx  = IDX_W'(i);
                best_prio = prio_flat[i*PRIO_W +: PRIO_W];
            end
        end
    end

endmodule

// File: rtl/grp_irq_preempt_judge.sv
module grp_irq_preempt_judge #(
    parameter int PRIO_W = 5,
    parameter int GRP_W  = 3
) (
    input  logic [GRP_W-1:0]  grouping,
    input  logic [PRIO_W-1:0] cand_prio,
    input  logic              act_valid,
    input  logic [PRIO_W-1:0] act_prio,
    output logic              may_preempt
);

    localparam int TOP_CODE = (1 << GRP_W) - 1;
    localparam int OFFSET   = TOP_CODE - PRIO_W;

    int unsigned       sub_bits;
    logic [PRIO_W-1:0] cand_grp;
    logic [PRIO_W-1:0] act_grp;

    always_comb begin
        if (int'(grouping) <= OFFSET) begin
            sub_bits = 0;
        end else begin
            sub_bits = unsigned'(int'(grouping) - OFFSET);
        end
        cand_grp    = cand_prio >> sub_bits;
        act_grp     = act_prio >> sub_bits;
        may_preempt = !act_valid || (cand_grp < act_grp);
    end

endmodule

// File: rtl/grp_irq_select.sv
module grp_irq_select
    import grp_irq_pkg::*;
#(
    parameter int NUM_SRC = 35,
    parameter int PRIO_W  = 5,
    parameter int GRP_W   = 3,
    parameter int IDX_W   = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [IDX_W-1:0]   cfg_idx,
    input  logic [PRIO_W-1:0]  cfg_prio,
    input  logic               cfg_enable,
    input  logic [NUM_SRC-1:0] req_pending,
    input  logic [GRP_W-1:0]   grouping,
    input  logic               act_valid,
    input  logic [PRIO_W-1:0]  act_prio,
    output logic [IDX_W-1:0]   sel_idx,
    output logic               sel_valid,
    output logic               sel_preempt
);

    logic [NUM_SRC*PRIO_W-1:0] prio_flat;
    logic [NUM_SRC-1:0]        en_vec;
    logic [NUM_SRC-1:0]        live;
    logic                      any;
    logic [IDX_W-1:0]          best_idx;
    logic [PRIO_W-1:0]         best_prio;
    logic                      may_preempt;

    sel_state_e       state_q, state_d;
    logic [IDX_W-1:0] idx_q;

    grp_irq_prio_bank #(
        .NUM_SRC (NUM_SRC),
        .PRIO_W  (PRIO_W),
        .IDX_W   (IDX_W)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_idx    (cfg_idx),
        .cfg_prio   (cfg_prio),
        .cfg_enable (cfg_enable),
        .prio_flat  (prio_flat),
        .en_vec     (en_vec)
    );

    assign live = req_pending & en_vec;

    grp_irq_min_pick #(
        .NUM_SRC (NUM_SRC),
        .PRIO_W  (PRIO_W),
        .IDX_W   (IDX_W)
    ) u_pick (
        .live      (live),
        .prio_flat (prio_flat),
        .any       (any),
        .best_idx  (best_idx),
        .best_prio (best_prio)
    );

    grp_irq_preempt_judge #(
        .PRIO_W (PRIO_W),
        .GRP_W  (GRP_W)
    ) u_judge (
        .grouping    (grouping),
        .cand_prio   (best_prio),
        .act_valid   (act_valid),
        .act_prio    (act_prio),
        .may_preempt (may_preempt)
    );

    // Next-state decision: every state may move to any state each cycle.
    always_comb begin
        if (!any) begin
            state_d = SEL_IDLE;
        end else if (may_preempt) begin
            state_d = SEL_PREEMPT;
        end else begin
            state_d = SEL_QUEUE;
        end
    end

    // State register with the winning index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEL_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= any ? best_idx : '0;
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        sel_idx = idx_q;
        unique case (state_q)
            SEL_IDLE: begin
                sel_valid   = 1'b0;
                sel_preempt = 1'b0;
            end
            SEL_QUEUE: begin
                sel_valid   = 1'b1;
                sel_preempt = 1'b0;
            end
            SEL_PREEMPT: begin
                sel_valid   = 1'b1;
                sel_preempt = 1'b1;
            end
            default: begin
                sel_valid   = 1'b0;
                sel_preempt = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/grp_irq_select_chk.sv
module grp_irq_select_chk #(
    parameter int NUM_SRC = 35,
    parameter int PRIO_W  = 5,
    parameter int GRP_W   = 3,
    parameter int IDX_W   = $clog2(NUM_SRC)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cfg_we,
    input logic [IDX_W-1:0]   cfg_idx,
    input logic [PRIO_W-1:0]  cfg_prio,
    input logic               cfg_enable,
    input logic [NUM_SRC-1:0] req_pending,
    input logic [GRP_W-1:0]   grouping,
    input logic               act_valid,
    input logic [PRIO_W-1:0]  act_prio,
    input logic [IDX_W-1:0]   sel_idx,
    input logic               sel_valid,
    input logic               sel_preempt
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_SRC - 1);

    // Pending lines as seen at the edge that formed the current decision.
    logic [NUM_SRC-1:0] pend_seen;
    always_ff @(posedge clk) begin
        pend_seen <= req_pending;
    end

    // R3
    winner_was_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |-> pend_seen[sel_idx]);

    // R3
    idle_idx_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_valid |-> (sel_idx == '0 && !sel_preempt));

    // R10
    no_req_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_pending == '0) |-> !sel_valid);

    // R2
    idx_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_idx <= LAST_IDX);

    // R8
    free_core_preempts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!act_valid) && sel_valid) |-> sel_preempt);

    // R9
    top_group_unbeatable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(act_valid && act_prio == '0) |-> !sel_preempt);

endmodule

bind grp_irq_select grp_irq_select_chk #(
    .NUM_SRC (NUM_SRC),
    .PRIO_W  (PRIO_W),
    .GRP_W   (GRP_W),
    .IDX_W   (IDX_W)
) u_chk (.*);

// File: tb/test_grp_irq_select.sv
module test_grp_irq_select;

    localparam int N = 35;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [5:0]    cfg_idx = '0;
    logic [4:0]    cfg_prio = '0;
    logic          cfg_enable = 1'b0;
    logic [N-1:0]  req_pending = '0;
    logic [2:0]    grouping = '0;
    logic          act_valid = 1'b0;
    logic [4:0]    act_prio = '0;
    logic [5:0]    sel_idx;
    logic          sel_valid;
    logic          sel_preempt;

    int prio_m [N];
    bit en_m   [N];
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    grp_irq_select i_grp_irq_select (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_idx     (cfg_idx),
        .cfg_prio    (cfg_prio),
        .cfg_enable  (cfg_enable),
        .req_pending (req_pending),
        .grouping    (grouping),
        .act_valid   (act_valid),
        .act_prio    (act_prio),
        .sel_idx     (sel_idx),
        .sel_valid   (sel_valid),
        .sel_preempt (sel_preempt)
    );

    task automatic compare(input string tag, input bit ev, input int ei, input bit ep);
        checks++;
        if (sel_valid !== ev || int'(sel_idx) != ei || sel_preempt !== ep) begin
            fails++;
            $display("FAIL %s: got valid=%0b idx=%0d preempt=%0b, expected valid=%0b idx=%0d preempt=%0b",
                     tag, sel_valid, sel_idx, sel_preempt, ev, ei, ep);
        end
    endtask

    // Reference decision from the requirements, then one clock, then compare.
    task automatic step(input string tag);
        int best = -1;
        int sh;
        bit ev, ep;
        int ei;
        for (int s = 0; s < N; s++) begin
            if (req_pending[s] && en_m[s] && (best < 0 || prio_m[s] < prio_m[best])) best = s;
        end
        sh = (int'(grouping) <= 2) ? 0 : int'(grouping) - 2;
        ev = (best >= 0);
        ei = ev ? best : 0;
        ep = ev && (!act_valid || ((prio_m[best] >> sh) < (int'(act_prio) >> sh)));
        if (cfg_we && int'(cfg_idx) < N) begin
            prio_m[cfg_idx] = int'(cfg_prio);
            en_m[cfg_idx]   = cfg_enable;
        end
        @(posedge clk);
        #1;
        compare(tag, ev, ei, ep);
    endtask

    task automatic wr(input int idx, input int p, input bit e);
        cfg_we     = 1'b1;
        cfg_idx    = 6'(idx);
        cfg_prio   = 5'(p);
        cfg_enable = e;
        step("R2");
        cfg_we = 1'b0;
    endtask

    function automatic logic [N-1:0] bits2(input int a, input int b);
        logic [N-1:0] v = '0;
        v[a] = 1'b1;
        v[b] = 1'b1;
        return v;
    endfunction

    initial begin
        for (int s = 0; s < N; s++) begin
            prio_m[s] = 0;
            en_m[s]   = 1'b0;
        end
        // R1: outputs held at zero during reset
        repeat (3) @(posedge clk);
        #1;
        compare("R1", 1'b0, 0, 1'b0);
        rst_n = 1'b1;
        req_pending = '1;
        step("R1");                 // all disabled after reset

        // Program priorities through the write port (R2)
        req_pending = '0;
        for (int s = 0; s < N; s++) wr(s, (s * 7 + 3) % 32, 1'b1);

        // R4: single and multiple pending
        req_pending = '0; req_pending[10] = 1'b1;
        step("R4");
        req_pending = '1;
        step("R4");

        // R6: equal values, lower index wins
        wr(7, 4, 1'b1);
        wr(34, 4, 1'b1);
        wr(3, 4, 1'b1);
        req_pending = bits2(34, 7);
        step("R6");
        req_pending = bits2(3, 34);
        step("R6");

        // R5: same group (grouping 4), lower tie-break level wins
        wr(20, 2, 1'b1);
        wr(21, 1, 1'b1);
        grouping = 3'd4;
        req_pending = bits2(20, 21);
        step("R5");
        req_pending = '0; req_pending[20] = 1'b1;
        step("R5");

        // R3: disabled pending source ignored
        wr(21, 1, 1'b0);
        req_pending = bits2(20, 21);
        step("R3");
        req_pending = '0; req_pending[21] = 1'b1;
        step("R3");

        // R2: out-of-range write ignored
        wr(40, 0, 1'b1);
        req_pending = bits2(20, 21);
        step("R2");

        // R8: no active handler
        act_valid = 1'b0;
        step("R8");

        // R9: same group, lower tie-break: no preempt
        wr(21, 1, 1'b1);
        act_valid = 1'b1; act_prio = 5'd3; grouping = 3'd4;
        req_pending = '0; req_pending[21] = 1'b1;
        step("R9");
        grouping = 3'd2;
        step("R9");
        act_prio = 5'd0;
        step("R9");

        // R7: sweep grouping with winner 15 against active 16
        wr(12, 15, 1'b1);
        req_pending = '0; req_pending[12] = 1'b1;
        act_prio = 5'd16;
        for (int g = 0; g < 8; g++) begin
            grouping = 3'(g);
            step("R7");
        end

        // R10: changes appear one cycle later, compared every cycle
        for (int k = 0; k < 400; k++) begin
            req_pending = {$urandom(), $urandom()} > 0 ? N'({$urandom(), $urandom()}) : '0;
            if (k % 9 == 0) req_pending = '0;
            grouping  = 3'($urandom_range(0, 7));
            act_valid = 1'($urandom_range(0, 1));
            act_prio  = 5'($urandom_range(0, 31));
            if (k % 5 == 0) begin
                cfg_we     = 1'b1;
                cfg_idx    = 6'($urandom_range(0, 40));
                cfg_prio   = 5'($urandom_range(0, 31));
                cfg_enable = ($urandom_range(0, 3) != 0);
            end
            step("R10");
            cfg_we = 1'b0;
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule